// File: doc/BRIEF.md
# Paired-Slot Stereo Channel Merger

This block sits between a frame serializer for a PCM audio link and the sample FIFOs that feed and drain it. It carries each stereo pair of slots through one FIFO channel. Channel 0 serves slots 3 and 4, and channel 1 serves slots 7 and 8. A channel word is 32 bits wide. Bits 15:0 hold the sample for the lower slot of the pair, and bits 31:16 hold the sample for the upper slot.

A strobe marks each frame boundary. At that strobe, the block looks at two things from the frame just received: the status word of slot 1 and the tag.

- **Transmit:** if the codec asks for the lower slot of a pair and the transmit FIFO has a word, the block pops that word. It splits the word into two slot samples for the next outgoing frame and marks both slots valid.
- **Receive:** if the lower slot's valid bit is set, the block joins the two received slots into one word and pushes it into the receive FIFO.

The codec's bits for the upper slot are never consulted, because they are assumed to track the lower slot.

The block does not cover DMA, bit serialization or any other slot.

Top module: `pair_slot_merger`

## Requirements
- R1: While `rst_n` is low and after its release, `tx_valid`, `tx_lo`, `tx_hi` and `overrun` are all zero, and `tx_fifo_pop` and `rx_fifo_push` stay low until a frame strobe calls for them.
- R2: `tx_fifo_pop[c]` is high during the cycle of `frame_tick` exactly when both of these hold:
  - the lower-slot request bit of that channel in `rx_slot1` is 0 (active low: bit 11 for channel 0, bit 7 for channel 1);
  - `tx_fifo_empty[c]` is 0.
- R3: After a pop, starting at the clock edge that ends the `frame_tick` cycle, the outputs are:
  - `tx_valid[c]` = 1;
  - the lower slot = word bits 15:0 in slot bits 19:4, with zeros in bits 3:0;
  - the upper slot = word bits 31:16, placed the same way.
- R4: When a channel is not requested or its transmit FIFO is empty at a frame strobe, it does not pop. Its `tx_valid` becomes 0, and both of its 20-bit slot outputs become zero.
- R5: The upper-slot request bits (`rx_slot1` bit 10 for channel 0, bit 6 for channel 1) have no effect on popping or on the transmit outputs.
- R6: `rx_fifo_push[c]` is high during the `frame_tick` cycle exactly when both of these hold:
  - the lower-slot valid bit of `rx_tag` is 1 (bit 12 for slot 3, bit 8 for slot 7);
  - `rx_fifo_full[c]` is 0.

  While it is high, the word is {upper slot bits 19:4, lower slot bits 19:4}.
- R7: The upper-slot valid bits (`rx_tag` bit 11 for slot 4, bit 7 for slot 8) and bits 3:0 of the received slots have no effect on pushing or on the pushed word.
- R8: A valid lower slot at a strobe while `rx_fifo_full[c]` is 1 causes no push and sets `overrun[c]`. Only reset clears `overrun[c]`.
- R9: Without `frame_tick`, nothing pops or pushes, and the transmit outputs and `overrun` hold their values.
- R10: The channels act independently: each channel's decisions depend only on its own bits and FIFO status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle strobe at each frame boundary |
| rx_tag | input | 16 | Received tag word; slot n valid at bit 15-n |
| rx_slot1 | input | 20 | Received slot 1; slot n request (active low) at bit 14-n |
| rx_lo | input | NCH*20 | Received lower-slot data, channel c at bits c*20 +: 20 |
| rx_hi | input | NCH*20 | Received upper-slot data, same layout |
| tx_fifo_empty | input | NCH | Transmit FIFO of channel c is empty |
| tx_fifo_data | input | NCH*32 | Head word of each transmit FIFO |
| tx_fifo_pop | output | NCH | Pop strobe per channel |
| rx_fifo_full | input | NCH | Receive FIFO of channel c is full |
| rx_fifo_push | output | NCH | Push strobe per channel |
| rx_fifo_data | output | NCH*32 | Joined word per channel |
| tx_valid | output | NCH | Both slots of pair c are valid in the outgoing frame |
| tx_lo | output | NCH*20 | Outgoing lower-slot data |
| tx_hi | output | NCH*20 | Outgoing upper-slot data |
| overrun | output | NCH | Sticky receive overrun per channel |

## Verification
The checker watches several rules on every cycle:
- pops happen only on a strobe with data in the FIFO;
- pushes never go into a full FIFO;
- a non-valid channel sends zero data;
- an overrun flag never clears on its own;
- the transmit outputs stay put between strobes.

Other properties can only be shown by the bench's sweep over every combination of per-channel bits:
- that the correct request and valid bit positions are decoded;
- that the upper-slot bits are truly ignored;
- that the samples land in the right slot bit positions;
- that a request acts on the very next outgoing frame.

// File: rtl/pair_slot_merger.sv
module pair_slot_merger #(
  parameter int NCH    = 2,
  parameter int SLOT_W = 20,
  parameter int SAMP_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_tick,
  input  logic [15:0]            rx_tag,
  input  logic [SLOT_W-1:0]      rx_slot1,
  input  logic [NCH*SLOT_W-1:0]  rx_lo,
  input  logic [NCH*SLOT_W-1:0]  rx_hi,
  input  logic [NCH-1:0]         tx_fifo_empty,
  input  logic [NCH*2*SAMP_W-1:0] tx_fifo_data,
  output logic [NCH-1:0]         tx_fifo_pop,
  input  logic [NCH-1:0]         rx_fifo_full,
  output logic [NCH-1:0]         rx_fifo_push,
  output logic [NCH*2*SAMP_W-1:0] rx_fifo_data,
  output logic [NCH-1:0]         tx_valid,
  output logic [NCH*SLOT_W-1:0]  tx_lo,
  output logic [NCH*SLOT_W-1:0]  tx_hi,
  output logic [NCH-1:0]         overrun
);
  localparam int WORD_W = 2 * SAMP_W;
  localparam int PAD    = SLOT_W - SAMP_W;

  logic unused_bits;
  assign unused_bits = ^{rx_tag, rx_slot1, rx_lo, rx_hi};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int LOW_SLOT = 3 + 4 * c;

    logic wanted, arrived, take;
    assign wanted  = ~rx_slot1[14 - LOW_SLOT];
    assign arrived = rx_tag[15 - LOW_SLOT];
    assign take    = wanted & ~tx_fifo_empty[c];

    assign tx_fifo_pop[c]  = frame_tick & take;
    assign rx_fifo_push[c] = frame_tick & arrived & ~rx_fifo_full[c];
    assign rx_fifo_data[c*WORD_W +: WORD_W] =
      {rx_hi[c*SLOT_W+PAD +: SAMP_W], rx_lo[c*SLOT_W+PAD +: SAMP_W]};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tx_valid[c]                <= 1'b0;
        tx_lo[c*SLOT_W +: SLOT_W]  <= '0;
        tx_hi[c*SLOT_W +: SLOT_W]  <= '0;
        overrun[c]                 <= 1'b0;
      end else if (frame_tick) begin
        tx_valid[c] <= take;
        tx_lo[c*SLOT_W +: SLOT_W] <= take ?
          {tx_fifo_data[c*WORD_W +: SAMP_W], {PAD{1'b0}}} : '0;
        tx_hi[c*SLOT_W +: SLOT_W] <= take ?
          {tx_fifo_data[c*WORD_W+SAMP_W +: SAMP_W], {PAD{1'b0}}} : '0;
        if (arrived && rx_fifo_full[c])
          overrun[c] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pair_slot_merger_chk.sv
module pair_slot_merger_chk #(
  parameter int NCH    = 2,
  parameter int SLOT_W = 20
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  frame_tick,
  input logic [NCH-1:0]        tx_fifo_empty,
  input logic [NCH-1:0]        tx_fifo_pop,
  input logic [NCH-1:0]        rx_fifo_full,
  input logic [NCH-1:0]        rx_fifo_push,
  input logic [NCH-1:0]        tx_valid,
  input logic [NCH*SLOT_W-1:0] tx_lo,
  input logic [NCH*SLOT_W-1:0] tx_hi,
  input logic [NCH-1:0]        overrun
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    a_r2_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fifo_pop[c] |-> (frame_tick && !tx_fifo_empty[c]));
    a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fifo_push[c] |-> (frame_tick && !rx_fifo_full[c]));
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun[c] |=> overrun[c]);
    a_r4_idle_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_valid[c] |-> (tx_lo[c*SLOT_W +: SLOT_W] == '0 && tx_hi[c*SLOT_W +: SLOT_W] == '0));
    a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_tick |=> ($stable(tx_valid[c]) && $stable(tx_lo[c*SLOT_W +: SLOT_W])
                       && $stable(tx_hi[c*SLOT_W +: SLOT_W]) && $stable(overrun[c])));
  end
endmodule

bind pair_slot_merger pair_slot_merger_chk #(.NCH(NCH), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
  .tx_fifo_empty(tx_fifo_empty), .tx_fifo_pop(tx_fifo_pop),
  .rx_fifo_full(rx_fifo_full), .rx_fifo_push(rx_fifo_push),
  .tx_valid(tx_valid), .tx_lo(tx_lo), .tx_hi(tx_hi), .overrun(overrun));

// File: tb/pair_slot_merger_bench.sv
module pair_slot_merger_bench;
  localparam int NCH = 2;
  localparam int SW  = 20;
  localparam int WW  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0;
  logic [15:0] rx_tag = '0;
  logic [SW-1:0] rx_slot1 = '1;
  logic [NCH*SW-1:0] rx_lo = '0, rx_hi = '0;
  logic [NCH-1:0] tx_fifo_empty = '1, rx_fifo_full = '0;
  logic [NCH*WW-1:0] tx_fifo_data = '0;
  logic [NCH-1:0] tx_fifo_pop, rx_fifo_push, tx_valid, overrun;
  logic [NCH*WW-1:0] rx_fifo_data;
  logic [NCH*SW-1:0] tx_lo, tx_hi;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pair_slot_merger u_pair_slot_merger (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .rx_tag(rx_tag),
    .rx_slot1(rx_slot1), .rx_lo(rx_lo), .rx_hi(rx_hi),
    .tx_fifo_empty(tx_fifo_empty), .tx_fifo_data(tx_fifo_data),
    .tx_fifo_pop(tx_fifo_pop), .rx_fifo_full(rx_fifo_full),
    .rx_fifo_push(rx_fifo_push), .rx_fifo_data(rx_fifo_data),
    .tx_valid(tx_valid), .tx_lo(tx_lo), .tx_hi(tx_hi), .overrun(overrun));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [NCH-1:0] ov_exp;
  logic [NCH-1:0] v_exp;
  logic [NCH*SW-1:0] lo_exp, hi_exp;

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 tx_valid", 64'(tx_valid), 0);
    check("R1 tx_lo", 64'(tx_lo), 0);
    check("R1 tx_hi", 64'(tx_hi), 0);
    check("R1 overrun", 64'(overrun), 0);
    @(negedge clk) rst_n = 1'b1;
    #2;
    check("R1 pop", 64'(tx_fifo_pop), 0);
    check("R1 push", 64'(rx_fifo_push), 0);
    ov_exp = '0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      rx_slot1 = '1; rx_tag = '0;
      for (int c = 0; c < NCH; c++) begin
        automatic int k = (c == 0) ? i : 63 - i;
        automatic logic [WW-1:0] w = 32'(i * 32'h9E3779B1 + c * 32'h01234567);
        rx_slot1[11-4*c] = ~k[0];
        rx_slot1[10-4*c] = k[1];
        tx_fifo_empty[c] = k[2];
        rx_tag[12-4*c]   = k[3];
        rx_tag[11-4*c]   = k[4];
        rx_fifo_full[c]  = k[5];
        tx_fifo_data[c*WW +: WW] = w;
        rx_lo[c*SW +: SW] = 20'(i * 40503 + c * 1234 + 9);
        rx_hi[c*SW +: SW] = 20'(i * 9973 + c * 777 + 5);
      end
      frame_tick = 1'b1;
      #2;
      for (int c = 0; c < NCH; c++) begin
        automatic int k = (c == 0) ? i : 63 - i;
        automatic logic take = k[0] & ~k[2];
        automatic logic put  = k[3] & ~k[5];
        automatic logic [WW-1:0] w = tx_fifo_data[c*WW +: WW];
        check("R2 R5 R10 pop", 64'(tx_fifo_pop[c]), 64'(take));
        check("R6 R7 R10 push", 64'(rx_fifo_push[c]), 64'(put));
        if (put)
          check("R6 R7 joined word", 64'(rx_fifo_data[c*WW +: WW]),
                64'({rx_hi[c*SW+4 +: 16], rx_lo[c*SW+4 +: 16]}));
        if (k[3] && k[5]) ov_exp[c] = 1'b1;
        v_exp[c] = take;
        lo_exp[c*SW +: SW] = take ? {w[15:0], 4'h0} : 20'h0;
        hi_exp[c*SW +: SW] = take ? {w[31:16], 4'h0} : 20'h0;
      end
      @(posedge clk);
      #2;
      frame_tick = 1'b0;
      for (int c = 0; c < NCH; c++) begin
        check("R3 R4 tx_valid", 64'(tx_valid[c]), 64'(v_exp[c]));
        check("R3 R4 tx_lo", 64'(tx_lo[c*SW +: SW]), 64'(lo_exp[c*SW +: SW]));
        check("R3 R4 tx_hi", 64'(tx_hi[c*SW +: SW]), 64'(hi_exp[c*SW +: SW]));
        check("R8 overrun", 64'(overrun[c]), 64'(ov_exp[c]));
      end
      @(negedge clk);
      rx_slot1 = '0; rx_tag = '1; tx_fifo_empty = '0; rx_fifo_full = '1;
      tx_fifo_data = ~tx_fifo_data;
      #2;
      check("R9 no pop", 64'(tx_fifo_pop), 0);
      check("R9 no push", 64'(rx_fifo_push), 0);
      @(posedge clk);
      #2;
      check("R9 tx_valid held", 64'(tx_valid), 64'(v_exp));
      check("R9 tx_lo held", 64'(tx_lo), 64'(lo_exp));
      check("R9 tx_hi held", 64'(tx_hi), 64'(hi_exp));
      check("R9 overrun held", 64'(overrun), 64'(ov_exp));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule